// File: doc/BRIEF.md
# Destuffing Frame Receiver for NRZI-Decoded Serial Streams

This block sits behind a line sampler and NRZI decoder. It accepts one recovered bit for each pulse of a bit strobe. The strobe may have idle cycles between bits, so a sampler running at two or more times the bit rate can feed it directly.

The block first removes the filler 1 that a transmitter inserts after every run of six 0 bits. It then hunts for a run of three 1 bits, which marks the start of a frame. After that it collects one 16-bit header word and splits it into a 4-bit data type and a 10-bit payload word count. Finally it collects exactly that many 16-bit payload words and returns to hunting. A missing filler bit raises an error pulse and drops any frame in progress. A downstream FIFO is expected to take the header and payload strobes across clock domains.

The controller has three states:

| State | Role |
|-------|------|
| `ST_HUNT` | Counts consecutive destuffed 1s. |
| `ST_HEADER` | Assembles the header word. |
| `ST_PAYLOAD` | Assembles payload words and counts them down. |

Transitions:

- **sync found** (`ST_HUNT` to `ST_HEADER`): the third consecutive 1 arrives.
- **empty frame** (`ST_HEADER` to `ST_HUNT`): the header carries a count of zero.
- **body follows** (`ST_HEADER` to `ST_PAYLOAD`): the header carries a non-zero count.
- **frame done** (`ST_PAYLOAD` to `ST_HUNT`): the final word has been collected.
- **stuff abort** (any state to `ST_HUNT`): a filler-bit violation occurs.

Top module: `nrzi_frame_rx`

## Requirements
- R1: A 1 that arrives directly after six consecutive 0 bits is a filler bit. It is discarded and counts toward neither sync detection nor word assembly, so all-zero payload words arrive intact.
- R2: A 0 that arrives where a filler 1 is due is a stuffing violation. It pulses `err_stuff` for one cycle. If a frame is in progress (header or payload state), it also pulses `err_abort`. In every case the receiver returns to hunting with its zero-run count cleared.
- R3: A run of 0 bits of any length, with its filler 1s, produces no header, payload or error strobe.
- R4: In the hunt state, three consecutive destuffed 1 bits start a frame. A run of only one or two 1 bits followed by a 0 does not.
- R5: The 16 bits after the sync form the header, most significant bit first. `hdr_type` comes from bits 15:12 and `hdr_len` from bits 9:0. `hdr_vld` pulses for one cycle in the cycle after the strobe that carried the final header bit.
- R6: After a header with a non-zero count N, exactly N 16-bit words are assembled, most significant bit first. Each word is presented on `pay_data` with a one-cycle `pay_vld` pulse in the cycle after its final bit.
- R7: The N-th word of a frame carries `pay_last` = 1, and no other word does. After that word the receiver hunts for sync again.
- R8: A header whose count field is zero gives a `hdr_vld` pulse, no payload strobe, and a return to hunting.
- R9: Holding `rst` high at a clock edge returns the receiver to hunting, clears the zero-run count, and clears every strobe. A frame cut by the reset produces nothing further.
- R10: Header bits 11:10 have no effect on any output. A header with these bits set decodes to the same type and count as one with them clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe: `bit_in` carries a decoded bit this cycle |
| bit_in | input | 1 | Decoded bit value |
| hdr_vld | output | 1 | One-cycle pulse: header fields are valid |
| hdr_type | output | 4 | Data type from the header |
| hdr_len | output | 10 | Payload word count from the header |
| pay_vld | output | 1 | One-cycle pulse: `pay_data` holds a payload word |
| pay_data | output | 16 | Payload word |
| pay_last | output | 1 | Marks the final payload word of a frame |
| err_stuff | output | 1 | One-cycle pulse: stuffing violation |
| err_abort | output | 1 | One-cycle pulse: the violation cut short a frame |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 4-bit type, a 10-bit count, a three-bit sync and a six-zero run limit.

At these values, all-zero payload words force filler bits into the middle of data. The idle gap before each sync is long enough that a filler bit always precedes the first sync 1.

The bit strobe is driven back to back and with one or two empty cycles between bits. This exercises the path where the strobe is not continuous.

A reset that lands after five zeros would expose a zero-run count that survives reset: with the count left standing, the next frame would hit a false stuffing violation. Short frames, with counts of 0, 1 and 2, keep the end-of-frame, zero-count and last-word paths all within a short run.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rx_destuff.sv
module rx_destuff #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  logic in_bit,
    output logic out_vld,
    output logic out_bit,
    output logic stuff_err
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] zrun;
    logic          at_limit;

    always_comb begin
        at_limit  = (zrun == CW'(RUN_LEN));
        out_vld   = in_vld && !at_limit;
        out_bit   = in_bit;
        stuff_err = in_vld && at_limit && !in_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun <= '0;
        end else if (in_vld) begin
            if (at_limit || in_bit) begin
                zrun <= '0;
            end else begin
                zrun <= zrun + 1'b1;
            end
        end
    end

    // R1
    zrun_bound_chk: assert property (@(posedge clk) disable iff (rst)
        zrun <= CW'(RUN_LEN));

    // R2
    err_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
        stuff_err |=> (zrun == '0));

endmodule

// File: rtl/rx_word_asm.sv
module rx_word_asm #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              bit_in,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int BCW = $clog2(WORD_W);

    logic [BCW-1:0]    cnt;
    logic [WORD_W-1:0] sh;

    always_comb begin
        word      = {sh[WORD_W-2:0], bit_in};
        word_done = en && !clr && (cnt == BCW'(WORD_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            sh  <= '0;
        end else if (en) begin
            sh  <= word;
            cnt <= (cnt == BCW'(WORD_W - 1)) ? '0 : cnt + 1'b1;
        end
    end

    // R5
    wrap_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |=> (cnt == '0));

endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
    import nrzi_rx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int TYPE_W   = 4,
    parameter int LEN_W    = 10,
    parameter int SYNC_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              stuff_err,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    output logic              asm_clr,
    output logic              hdr_vld,
    output logic [TYPE_W-1:0] hdr_type,
    output logic [LEN_W-1:0]  hdr_len,
    output logic              pay_vld,
    output logic [WORD_W-1:0] pay_data,
    output logic              pay_last,
    output logic              err_stuff,
    output logic              err_abort
);
    localparam int OCW = $clog2(SYNC_LEN + 1);

    rx_state_e         state, nxt;
    logic [OCW-1:0]    ones_cnt;
    logic [LEN_W-1:0]  words_left;
    logic [LEN_W-1:0]  len_field;
    logic [TYPE_W-1:0] type_field;
    logic              sync_hit;
    logic              final_word;

    always_comb begin
        len_field  = word[LEN_W-1:0];
        type_field = word[WORD_W-1 -: TYPE_W];
        sync_hit   = bit_vld && bit_val && (ones_cnt == OCW'(SYNC_LEN - 1));
        final_word = (words_left == LEN_W'(1));
        asm_clr    = (state == ST_HUNT);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (stuff_err) begin
            nxt = ST_HUNT;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (sync_hit) nxt = ST_HEADER;
                end
                ST_HEADER: begin
                    if (word_done) nxt = (len_field == '0) ? ST_HUNT : ST_PAYLOAD;
                end
                ST_PAYLOAD: begin
                    if (word_done && final_word) nxt = ST_HUNT;
                end
                default: nxt = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HUNT;
        else     state <= nxt;
    end

    // outputs and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            ones_cnt   <= '0;
            words_left <= '0;
            hdr_vld    <= 1'b0;
            hdr_type   <= '0;
            hdr_len    <= '0;
            pay_vld    <= 1'b0;
            pay_data   <= '0;
            pay_last   <= 1'b0;
            err_stuff  <= 1'b0;
            err_abort  <= 1'b0;
        end else begin
            hdr_vld   <= 1'b0;
            pay_vld   <= 1'b0;
            pay_last  <= 1'b0;
            err_stuff <= stuff_err;
            err_abort <= stuff_err && (state != ST_HUNT);
            if (stuff_err) begin
                ones_cnt <= '0;
            end else begin
                unique case (state)
                    ST_HUNT: begin
                        if (bit_vld) begin
                            if (!bit_val || sync_hit) ones_cnt <= '0;
                            else                      ones_cnt <= ones_cnt + 1'b1;
                        end
                    end
                    ST_HEADER: begin
                        ones_cnt <= '0;
                        if (word_done) begin
                            hdr_vld    <= 1'b1;
                            hdr_type   <= type_field;
                            hdr_len    <= len_field;
                            words_left <= len_field;
                        end
                    end
                    ST_PAYLOAD: begin
                        ones_cnt <= '0;
                        if (word_done) begin
                            pay_vld    <= 1'b1;
                            pay_data   <= word;
                            pay_last   <= final_word;
                            words_left <= words_left - 1'b1;
                        end
                    end
                    default: ones_cnt <= '0;
                endcase
            end
        end
    end

    // R7
    last_with_word_chk: assert property (@(posedge clk) disable iff (rst)
        pay_last |-> pay_vld);

    // R7
    hunt_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        pay_last |-> (state == ST_HUNT));

    // R6
    word_from_payload_chk: assert property (@(posedge clk) disable iff (rst)
        pay_vld |-> ($past(state) == ST_PAYLOAD));

    // R2
    abort_needs_stuff_chk: assert property (@(posedge clk) disable iff (rst)
        err_abort |-> err_stuff);

    // R5
    hdr_pay_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hdr_vld && pay_vld));

endmodule

// File: rtl/nrzi_frame_rx.sv
module nrzi_frame_rx #(
    parameter int WORD_W   = 16,
    parameter int TYPE_W   = 4,
    parameter int LEN_W    = 10,
    parameter int SYNC_LEN = 3,
    parameter int RUN_LEN  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              hdr_vld,
    output logic [TYPE_W-1:0] hdr_type,
    output logic [LEN_W-1:0]  hdr_len,
    output logic              pay_vld,
    output logic [WORD_W-1:0] pay_data,
    output logic              pay_last,
    output logic              err_stuff,
    output logic              err_abort
);
    logic              clean_vld;
    logic              clean_bit;
    logic              stuff_err;
    logic              asm_clr;
    logic              word_done;
    logic [WORD_W-1:0] word;

    rx_destuff #(.RUN_LEN(RUN_LEN)) u_destuff (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (bit_vld),
        .in_bit    (bit_in),
        .out_vld   (clean_vld),
        .out_bit   (clean_bit),
        .stuff_err (stuff_err)
    );

    rx_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .clr       (asm_clr),
        .en        (clean_vld),
        .bit_in    (clean_bit),
        .word_done (word_done),
        .word      (word)
    );

    rx_frame_ctl #(
        .WORD_W   (WORD_W),
        .TYPE_W   (TYPE_W),
        .LEN_W    (LEN_W),
        .SYNC_LEN (SYNC_LEN)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (clean_vld),
        .bit_val   (clean_bit),
        .stuff_err (stuff_err),
        .word_done (word_done),
        .word      (word),
        .asm_clr   (asm_clr),
        .hdr_vld   (hdr_vld),
        .hdr_type  (hdr_type),
        .hdr_len   (hdr_len),
        .pay_vld   (pay_vld),
        .pay_data  (pay_data),
        .pay_last  (pay_last),
        .err_stuff (err_stuff),
        .err_abort (err_abort)
    );

endmodule

// File: tb/tb_nrzi_frame_rx.sv
module tb_nrzi_frame_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        hdr_vld;
    logic [3:0]  hdr_type;
    logic [9:0]  hdr_len;
    logic        pay_vld;
    logic [15:0] pay_data;
    logic        pay_last;
    logic        err_stuff;
    logic        err_abort;

    always #10 clk = ~clk;

    nrzi_frame_rx dut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .hdr_vld(hdr_vld), .hdr_type(hdr_type), .hdr_len(hdr_len),
        .pay_vld(pay_vld), .pay_data(pay_data), .pay_last(pay_last),
        .err_stuff(err_stuff), .err_abort(err_abort)
    );

    int checks = 0;
    int fails = 0;
    int tx_zeros = 0;
    int gap = 0;
    int hdr_seen = 0;
    int pay_seen = 0;
    int stuff_seen = 0;
    int abort_seen = 0;
    bit finished = 0;

    logic [13:0] hdr_q[$];
    logic [16:0] pay_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // drive one line bit; caller is at a falling edge
    task automatic raw_bit(input logic b);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // transmitter model with filler insertion
    task automatic log_bit(input logic b);
        raw_bit(b);
        if (b) tx_zeros = 0;
        else begin
            tx_zeros++;
            if (tx_zeros == 6) begin
                raw_bit(1'b1);
                tx_zeros = 0;
            end
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) log_bit(w[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) log_bit(1'b0);
    endtask

    function automatic logic [15:0] pat(input int seed, input int k);
        if (seed == 0) return 16'h0000;
        return 16'(seed * 16'h9E37) ^ 16'(k * 16'h1F35);
    endfunction

    task automatic send_frame(input logic [3:0] ty, input logic [1:0] rsv,
                              input logic [9:0] len, input int seed);
        idle(9);
        for (int i = 0; i < 3; i++) log_bit(1'b1);
        hdr_q.push_back({ty, len});
        send_word({ty, rsv, len});
        for (int k = 0; k < int'(len); k++) begin
            pay_q.push_back({pat(seed, k), (k == int'(len) - 1)});
            send_word(pat(seed, k));
        end
    endtask

    task automatic settle_and_drain(input string tag);
        idle(4);
        repeat (3) @(negedge clk);
        check(hdr_q.size() == 0, tag, hdr_q.size(), 0);
        check(pay_q.size() == 0, tag, pay_q.size(), 0);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (hdr_vld) begin
                    hdr_seen++;
                    if (hdr_q.size() == 0) check(1'b0, "R5 unexpected header", {hdr_type, hdr_len}, 0);
                    else begin
                        logic [13:0] e;
                        e = hdr_q.pop_front();
                        check({hdr_type, hdr_len} == e, "R5 R10 header fields", {hdr_type, hdr_len}, e);
                    end
                end
                if (pay_vld) begin
                    pay_seen++;
                    if (pay_q.size() == 0) check(1'b0, "R6 unexpected word", pay_data, 0);
                    else begin
                        logic [16:0] e;
                        e = pay_q.pop_front();
                        check(pay_data == e[16:1], "R6 payload word", pay_data, e[16:1]);
                        check(pay_last == e[0], "R7 last flag", pay_last, e[0]);
                    end
                end
                if (err_stuff) stuff_seen++;
                if (err_abort) abort_seen++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int h0;
        int p0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check({hdr_vld, pay_vld, pay_last, err_stuff, err_abort} == 5'b0,
              "R9 outputs in reset", {hdr_vld, pay_vld, pay_last, err_stuff, err_abort}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R3 long idle gives nothing
        gap = 1;
        idle(40);
        check(hdr_seen == 0 && pay_seen == 0 && stuff_seen == 0, "R3 idle quiet",
              hdr_seen + pay_seen + stuff_seen, 0);

        // basic frame, back-to-back bits
        gap = 0;
        send_frame(4'h7, 2'b00, 10'd3, 5);
        settle_and_drain("R6 frame drained");

        // R1 all-zero payload words need filler bits inside data
        gap = 2;
        send_frame(4'h3, 2'b00, 10'd2, 0);
        settle_and_drain("R1 zero payload drained");

        // R8 zero-length frame
        gap = 1;
        p0 = pay_seen;
        h0 = hdr_seen;
        send_frame(4'hC, 2'b00, 10'd0, 9);
        settle_and_drain("R8 drained");
        check(hdr_seen == h0 + 1, "R8 header seen", hdr_seen - h0, 1);
        check(pay_seen == p0, "R8 no payload", pay_seen - p0, 0);

        // R10 reserved header bits ignored
        gap = 0;
        send_frame(4'hA, 2'b11, 10'd1, 3);
        settle_and_drain("R10 drained");

        // R4 two ones are not a sync
        h0 = hdr_seen;
        idle(8);
        log_bit(1'b1); log_bit(1'b1); log_bit(1'b0);
        idle(20);
        check(hdr_seen == h0, "R4 false sync", hdr_seen - h0, 0);
        send_frame(4'h1, 2'b00, 10'd2, 11);
        settle_and_drain("R4 real sync drained");

        // R2 violation while hunting
        log_bit(1'b1);
        for (int i = 0; i < 7; i++) raw_bit(1'b0);
        tx_zeros = 0;
        repeat (3) @(negedge clk);
        check(stuff_seen == 1, "R2 hunt stuff error", stuff_seen, 1);
        check(abort_seen == 0, "R2 no abort in hunt", abort_seen, 0);

        // R2 violation mid-frame
        idle(9);
        for (int i = 0; i < 3; i++) log_bit(1'b1);
        hdr_q.push_back({4'h5, 10'd4});
        send_word({4'h5, 2'b00, 10'd4});
        pay_q.push_back({pat(21, 0), 1'b0});
        send_word(pat(21, 0));
        log_bit(1'b1);
        for (int i = 0; i < 7; i++) raw_bit(1'b0);
        tx_zeros = 0;
        repeat (3) @(negedge clk);
        check(stuff_seen == 2, "R2 frame stuff error", stuff_seen, 2);
        check(abort_seen == 1, "R2 frame abort", abort_seen, 1);
        send_frame(4'h6, 2'b00, 10'd2, 17);
        settle_and_drain("R2 recovery drained");

        // R9 reset mid-header with a pending zero run
        gap = 1;
        idle(9);
        for (int i = 0; i < 3; i++) log_bit(1'b1);
        for (int i = 0; i < 8; i++) log_bit((i == 0 || i == 2) ? 1'b1 : 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        tx_zeros = 0;
        h0 = stuff_seen;
        send_frame(4'h9, 2'b01, 10'd2, 13);
        settle_and_drain("R9 after reset drained");
        check(stuff_seen == h0, "R9 run cleared by reset", stuff_seen - h0, 0);

        check(stuff_seen == 2 && abort_seen == 1, "R2 final error counts",
              stuff_seen * 16 + abort_seen, 33);
        summary();
    end

endmodule